// File: doc/BRIEF.md
# Additive Bit-Stream Scrambler

This block whitens a serial bit stream by combining each accepted data bit with a pseudorandom keystream bit through exclusive-OR. The keystream comes from a seven-stage linear-feedback shift register built on the polynomial x^7 + x^4 + 1, the sequence used by wireless LAN physical layers. The register is driven only by its own feedback and never by the data, so scrambling is additive and the same circuit, started from the same seed, undoes its own work.

A seed strobe loads a new register value, normally at the start of each frame; the reset value is all ones. Each data bit presented with its valid flag moves the register on by one step and produces one result bit, registered, one cycle later. Cycles without a valid bit leave the keystream where it was.

Top module: `scr_additive`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `dout_valid` and `dout` are 0, and the register holds all ones (0b1111111).
- R2: The keystream bit is stage 7 XOR stage 4, where stage 7 is the oldest bit; that bit enters stage 1 at each advance. From the all-ones seed, the first eight keystream bits in time order are 0,0,0,0,1,1,1,0.
- R3: A bit accepted with `din_valid` high appears on `dout` as `din` XOR the current keystream bit, with `dout_valid` high, exactly one cycle later; `dout_valid` is low one cycle after any cycle with `din_valid` low.
- R4: The register advances once per accepted bit and holds on every cycle without one, so idle gaps of any length do not change the result stream.
- R5: `seed_load` overrides any advance in its cycle: the register takes `seed_value` (bit 6 is stage 7, bit 0 is stage 1). A bit accepted in that same cycle is combined with the keystream of the register before the load.
- R6: From any nonzero seed the keystream repeats with period 127; after the all-ones seed, keystream bit k+127 equals bit k.
- R7: Feeding the scrambled output back through the block after reloading the same seed restores the original data bit for bit.
- R8: After an all-zero seed the register stays zero, and data passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| seed_load | input | 1 | Load `seed_value` into the register this cycle |
| seed_value | input | 7 | Seed; bit 6 is stage 7, bit 0 is stage 1 |
| din | input | 1 | Data bit |
| din_valid | input | 1 | `din` is accepted this cycle |
| dout | output | 1 | Scrambled (or descrambled) bit, registered |
| dout_valid | output | 1 | `dout` holds a new result |

## Verification
Every result is due exactly one cycle after its input bit is accepted, and a seed load changes the keystream from the next accepted bit onward. The driver applies inputs on the falling edge and, for each accepted bit, queues the expected result from an independent reference register. The monitor samples on the next falling edge whenever `dout_valid` is high and compares the oldest queued item, so a late, early, missing or extra result shows up as a mismatch or as items left in the queue. Idle gaps, a load together with a valid bit, a full double period, a round trip and a zero seed each get their own stretch of stimulus.

// File: rtl/scr_pkg.sv
package scr_pkg;
  parameter int unsigned SCR_LEN    = 7;
  parameter int unsigned SCR_TAP_HI = 7;
  parameter int unsigned SCR_TAP_LO = 4;

  typedef struct packed {
    logic data;
    logic valid;
  } scr_bit_t;
endpackage

// File: rtl/scr_keystream.sv
module scr_keystream #(
  parameter int unsigned LEN    = scr_pkg::SCR_LEN,
  parameter int unsigned TAP_HI = scr_pkg::SCR_TAP_HI,
  parameter int unsigned TAP_LO = scr_pkg::SCR_TAP_LO,
  parameter logic [LEN-1:0] SEED = '1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [LEN-1:0] load_val,
  input  logic           advance,
  output logic           ks
);
  localparam int unsigned HI = TAP_HI - 1;
  localparam int unsigned LO = TAP_LO - 1;

  logic [LEN-1:0] state;
  logic [LEN-1:0] state_nx;

  assign ks = state[HI] ^ state[LO];

  always_comb begin
    state_nx = state;
    if (load)
      state_nx = load_val;
    else if (advance)
      state_nx = {state[LEN-2:0], ks};
  end

  always_ff @(posedge clk) begin
    if (rst)
      state <= SEED;
    else
      state <= state_nx;
  end

  // R4: no accepted bit and no load keeps the register still
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!advance && !load) |=> $stable(state));
  // R5: a load wins over an advance
  p_load_r5: assert property (@(posedge clk) disable iff (rst)
    load |=> state == $past(load_val));
  // R2: an advance moves every stage one place toward the oldest end
  p_shift_r2: assert property (@(posedge clk) disable iff (rst)
    (advance && !load) |=> state[LEN-1:1] == $past(state[LEN-2:0]));
  // R8: a zero register never leaves zero on its own
  p_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (state == '0 && !load) |=> state == '0);
  // R1: reset leaves the seed value in place
  p_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> state == SEED);
endmodule

// File: rtl/scr_combine.sv
module scr_combine (
  input  logic              clk,
  input  logic              rst,
  input  logic              din,
  input  logic              din_valid,
  input  logic              ks,
  output scr_pkg::scr_bit_t q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      q.valid <= din_valid;
      if (din_valid)
        q.data <= din ^ ks;
    end
  end

  // R3: the result carries the input bit and keystream of the previous cycle
  p_data_r3: assert property (@(posedge clk) disable iff (rst)
    din_valid |=> (q.valid && q.data == ($past(din) ^ $past(ks))));
  // R3: no accepted bit, no result
  p_novalid_r3: assert property (@(posedge clk) disable iff (rst)
    !din_valid |=> !q.valid);
  // R1: outputs are quiet right after reset
  p_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!q.valid && !q.data));
endmodule

// File: rtl/scr_additive.sv
module scr_additive #(
  parameter int unsigned LEN    = scr_pkg::SCR_LEN,
  parameter int unsigned TAP_HI = scr_pkg::SCR_TAP_HI,
  parameter int unsigned TAP_LO = scr_pkg::SCR_TAP_LO,
  parameter logic [LEN-1:0] SEED = '1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           seed_load,
  input  logic [LEN-1:0] seed_value,
  input  logic           din,
  input  logic           din_valid,
  output logic           dout,
  output logic           dout_valid
);
  logic              ks;
  scr_pkg::scr_bit_t res;

  scr_keystream #(
    .LEN(LEN), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO), .SEED(SEED)
  ) u_ks (
    .clk(clk), .rst(rst), .load(seed_load), .load_val(seed_value),
    .advance(din_valid), .ks(ks)
  );

  scr_combine u_comb (
    .clk(clk), .rst(rst), .din(din), .din_valid(din_valid), .ks(ks), .q(res)
  );

  assign dout       = res.data;
  assign dout_valid = res.valid;

  // R3: one result per accepted bit, one cycle later
  p_latency_r3: assert property (@(posedge clk) disable iff (rst)
    dout_valid == $past(din_valid));
endmodule

// File: tb/scr_additive_test.sv
module scr_additive_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic seed_load = 1'b0;
  logic [6:0] seed_value = '0;
  logic din = 1'b0;
  logic din_valid = 1'b0;
  logic dout, dout_valid;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic  exp_q[$];
  string tag_q[$];
  logic  cap_q[$];
  logic [6:0] mstate = 7'h7F;
  logic ks_ref[127];

  always #10 clk = ~clk;

  scr_additive uut (
    .clk(clk), .rst(rst), .seed_load(seed_load), .seed_value(seed_value),
    .din(din), .din_valid(din_valid), .dout(dout), .dout_valid(dout_valid)
  );

  function automatic logic mks(input logic [6:0] s);
    return s[6] ^ s[3];
  endfunction

  function automatic logic [6:0] mstep(input logic [6:0] s);
    return {s[5:0], s[6] ^ s[3]};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send_exp(input logic b, input logic e, input string tag);
    @(negedge clk);
    din = b; din_valid = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    mstate = mstep(mstate);
  endtask

  task automatic send(input logic b, input string tag);
    send_exp(b, b ^ mks(mstate), tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      din_valid = 1'b0; seed_load = 1'b0;
    end
  endtask

  task automatic load(input logic [6:0] v);
    @(negedge clk);
    din_valid = 1'b0; seed_load = 1'b1; seed_value = v;
    mstate = v;
    @(negedge clk);
    seed_load = 1'b0;
  endtask

  task automatic drain();
    idle(3);
  endtask

  // monitor: compare each result against the oldest queued expectation
  always @(negedge clk) begin
    if (!rst && dout_valid) begin
      cap_q.push_back(dout);
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected result", 1, 0);
      end else begin
        logic e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(dout === e, t, int'(dout), int'(e));
      end
    end
  end

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [6:0] s;
    logic msg[40];
    s = 7'h7F;
    for (int i = 0; i < 127; i++) begin
      ks_ref[i] = mks(s);
      s = mstep(s);
    end

    repeat (3) @(negedge clk);
    check(dout_valid === 1'b0, "R1 valid in reset", int'(dout_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check(dout_valid === 1'b0, "R1 valid after reset", int'(dout_valid), 0);
    check(dout === 1'b0, "R1 dout after reset", int'(dout), 0);

    // R2: first eight keystream bits from the all-ones reset seed
    send_exp(1'b0, 1'b0, "R2 ks0");
    send_exp(1'b0, 1'b0, "R2 ks1");
    send_exp(1'b0, 1'b0, "R2 ks2");
    send_exp(1'b0, 1'b0, "R2 ks3");
    send_exp(1'b0, 1'b1, "R2 ks4");
    send_exp(1'b0, 1'b1, "R2 ks5");
    send_exp(1'b0, 1'b1, "R2 ks6");
    send_exp(1'b0, 1'b0, "R2 ks7");
    drain();

    // R3: ones in, complemented keystream out
    for (int i = 0; i < 16; i++) send(1'b1, "R3 ones");
    drain();
    check(!dout_valid, "R3 valid drops", int'(dout_valid), 0);

    // R4: irregular idle gaps
    for (int i = 0; i < 24; i++) begin
      send(logic'((i * 5) % 3 == 0), "R4 gaps");
      idle(i % 4);
    end
    drain();

    // R6: two full periods from the all-ones seed
    load(7'h7F);
    for (int i = 0; i < 127; i++) send_exp(1'b0, ks_ref[i], "R6 first period");
    for (int i = 0; i < 127; i++) send_exp(1'b0, ks_ref[i], "R6 second period");
    drain();

    // R5: load with a bit in the same cycle uses the old keystream
    load(7'h35);
    send(1'b1, "R5 after load");
    send(1'b0, "R5 after load");
    @(negedge clk);
    seed_load = 1'b1; seed_value = 7'h4A; din = 1'b1; din_valid = 1'b1;
    exp_q.push_back(1'b1 ^ mks(mstate)); tag_q.push_back("R5 same cycle");
    mstate = 7'h4A;
    @(negedge clk);
    seed_load = 1'b0; din_valid = 1'b0;
    for (int i = 0; i < 20; i++) send(logic'(i[0]), "R5 new seed");
    drain();

    // R7: round trip
    for (int i = 0; i < 40; i++) msg[i] = logic'(((i * 7) + (i >> 2)) % 3 == 1);
    load(7'h5C);
    cap_q.delete();
    for (int i = 0; i < 40; i++) send(msg[i], "R7 scramble");
    drain();
    check(cap_q.size() == 40, "R7 captured count", cap_q.size(), 40);
    load(7'h5C);
    for (int i = 0; i < 40; i++) begin
      logic c;
      c = (cap_q.size() > 0) ? cap_q.pop_front() : 1'b0;
      send_exp(c, msg[i], "R7 restore");
    end
    drain();

    // R8: zero seed passes data through
    load(7'h00);
    for (int i = 0; i < 20; i++) begin
      send_exp(logic'((i % 5) < 2), logic'((i % 5) < 2), "R8 zero seed");
      idle(i % 2);
    end
    drain();

    check(exp_q.size() == 0, "R3 all results arrived", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule